// File: doc/BRIEF.md
# Reset Release Sequencer with Configuration Strap Latch

This block converts an active-low board reset pin into the internal core reset of the chip. A low on the pin forces the core into reset at once, even with no clock running. The release is different: it passes through a two-flop synchronizer and then a fixed hold count of sixteen system clock cycles. Only after that count does the core leave reset, so the core always leaves reset cleanly on a clock edge.

While the board reset is held, the block samples two dual-purpose pins and latches their levels as configuration straps. The first strap picks the reference clock source: 0 means the crystal oscillator and 1 means the external clock input. The second strap picks the host link type: 0 means the serial host link and 1 is a reserved code. After the release the pins serve as ordinary GPIOs, and the latched copies stay fixed.

The block also drives a pad output-enable that stays inactive until the core reset has cleared. When the core comes out of reset, it raises a sticky ready interrupt for the external host. The host clears this flag with a write-one-to-clear strobe. If the reserved host-link code was latched, an error flag is raised, and the ready interrupt is still raised as well.

Top module: `rst_seq_strap`

## Requirements
- R1: A low on `ext_rst_n` drives `core_rst_n`, `pad_oe` and `rdy_irq` low in the same clock period, with no clock edge needed.
- R2: After `ext_rst_n` rises between two clock edges, `core_rst_n` stays low through the 17th rising edge and goes high after the 18th. That is 2 synchronizer cycles followed by 16 hold cycles.
- R3: With the clock stopped, `core_rst_n` stays low after `ext_rst_n` rises. The release completes only once the clock runs.
- R4: If `ext_rst_n` goes low part way through the hold count, the count restarts. The full 18-edge delay then applies from the next rise.
- R5: `clk_src_sel` holds the level of `strap_clk` at the time reset was released (0 = crystal, 1 = external clock input).
- R6: `host_if_sel` holds the level of `strap_host` at the time reset was released (0 = serial host link, 1 = reserved). Once `core_rst_n` is high, changes on either strap pin leave both latched outputs unchanged.
- R7: `pad_oe` is low while `core_rst_n` is low and high once it has gone high.
- R8: `rdy_irq` rises on the same edge on which `core_rst_n` rises. It then stays high until it is cleared.
- R9: When `rdy_clr` is high at a rising edge while the core is out of reset, `rdy_irq` goes low after that edge. A `rdy_clr` strobe given during reset has no effect on the interrupt that follows the release.
- R10: `host_if_err` is high exactly when the core is out of reset and the latched host-link code is 1. The ready interrupt is still raised in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| ext_rst_n | input | 1 | Asynchronous active-low board reset |
| strap_clk | input | 1 | Clock-source strap pin |
| strap_host | input | 1 | Host-link strap pin |
| rdy_clr | input | 1 | Write-one-to-clear strobe for the ready flag |
| core_rst_n | output | 1 | Internal core reset, active low |
| clk_src_sel | output | 1 | Latched clock-source select |
| host_if_sel | output | 1 | Latched host-link select |
| host_if_err | output | 1 | Reserved host-link code latched |
| pad_oe | output | 1 | Pad output enable, low during reset |
| rdy_irq | output | 1 | Sticky ready interrupt |

## Verification
The hardest case to reach from the ports is a release attempted with no clock running, followed later by a clock that starts. The bench gates its own clock off, toggles the reset pin, and checks that the core stays in reset. It then restarts the clock and checks that the release completes. A second hard case is a reset pulse arriving in the middle of the hold count. The bench pulses the reset pin after a counted number of edges and re-measures the full 18-edge delay from the second rise. Strap capture is checked by changing both pins right after the release and confirming that the latched outputs hold.

// File: rtl/rst_seq_strap.sv
module rst_seq_strap #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic strap_clk,
  input  logic strap_host,
  input  logic rdy_clr,
  output logic core_rst_n,
  output logic clk_src_sel,
  output logic host_if_sel,
  output logic host_if_err,
  output logic pad_oe,
  output logic rdy_irq
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] HOLD_MAX = CW'(HOLD_CYCLES);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0] cnt;
  logic released_sync;
  logic release_now;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n) sync_q <= '0;
    else            sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};

  assign released_sync = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n)                          cnt <= '0;
    else if (released_sync && cnt != HOLD_MAX) cnt <= cnt + 1'b1;

  assign release_now = released_sync && (cnt == HOLD_LAST);
  assign core_rst_n  = (cnt == HOLD_MAX);
  assign pad_oe      = core_rst_n;

  always_ff @(posedge clk)
    if (!released_sync) begin
      clk_src_sel <= strap_clk;
      host_if_sel <= strap_host;
    end

  assign host_if_err = core_rst_n & host_if_sel;

  always_ff @(posedge clk or negedge ext_rst_n)
    if (!ext_rst_n)       rdy_irq <= 1'b0;
    else if (release_now) rdy_irq <= 1'b1;
    else if (rdy_clr)     rdy_irq <= 1'b0;

  p_async_hold_r1: assert property (@(posedge clk)
    !ext_rst_n |-> (!core_rst_n && !rdy_irq));

  p_release_count_r2: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> ($past(cnt) == HOLD_LAST && $past(released_sync)));

  p_straps_frozen_r6: assert property (@(posedge clk) disable iff (!ext_rst_n)
    core_rst_n |=> ($stable(clk_src_sel) && $stable(host_if_sel)));

  p_irq_on_release_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    $rose(core_rst_n) |-> rdy_irq);

  p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (rdy_irq && !rdy_clr) |=> rdy_irq);

  p_irq_clear_r9: assert property (@(posedge clk) disable iff (!ext_rst_n)
    (core_rst_n && rdy_clr) |=> !rdy_irq);
endmodule

// File: tb/tb_rst_seq_strap.sv
module tb_rst_seq_strap;
  localparam int RELEASE_EDGES = 18;

  logic clk = 1'b0, clk_en = 1'b1;
  logic ext_rst_n = 1'b1, strap_clk = 1'b1, strap_host = 1'b0, rdy_clr = 1'b0;
  logic core_rst_n, clk_src_sel, host_if_sel, host_if_err, pad_oe, rdy_irq;
  int n_run = 0, n_fail = 0;

  rst_seq_strap dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .strap_clk(strap_clk), .strap_host(strap_host),
    .rdy_clr(rdy_clr), .core_rst_n(core_rst_n), .clk_src_sel(clk_src_sel),
    .host_if_sel(host_if_sel), .host_if_err(host_if_err), .pad_oe(pad_oe), .rdy_irq(rdy_irq));

  always #4 clk = clk_en ? ~clk : clk;

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edge1();
    @(posedge clk); #1;
  endtask

  task automatic enter_reset(input logic sc, input logic sh);
    @(posedge clk); #2;
    ext_rst_n = 1'b0;
    strap_clk = sc; strap_host = sh;
    #1;
    repeat (3) edge1();
    #1 ext_rst_n = 1'b1;
  endtask

  // {strap_clk, strap_host}
  localparam logic [1:0] VEC [4] = '{2'b10, 2'b00, 2'b11, 2'b01};

  initial begin
    #1 ext_rst_n = 1'b0;
    edge1();
    chk("R1 reset core", core_rst_n, 0);
    chk("R7 reset oe", pad_oe, 0);
    chk("R8 reset irq", rdy_irq, 0);

    for (int v = 0; v < 4; v++) begin
      enter_reset(VEC[v][1], VEC[v][0]);
      repeat (RELEASE_EDGES - 1) edge1();
      chk("R2 still held", core_rst_n, 0);
      chk("R7 oe held", pad_oe, 0);
      edge1();
      chk("R2 released", core_rst_n, 1);
      chk("R7 oe on", pad_oe, 1);
      chk("R8 irq raised", rdy_irq, 1);
      chk("R5 clk strap", clk_src_sel, VEC[v][1]);
      chk("R6 host strap", host_if_sel, VEC[v][0]);
      chk("R10 err", host_if_err, VEC[v][0]);
      strap_clk = ~VEC[v][1]; strap_host = ~VEC[v][0];
      repeat (3) edge1();
      chk("R6 clk frozen", clk_src_sel, VEC[v][1]);
      chk("R6 host frozen", host_if_sel, VEC[v][0]);
      chk("R8 irq sticky", rdy_irq, 1);
      rdy_clr = 1'b1; edge1(); rdy_clr = 1'b0;
      chk("R9 irq cleared", rdy_irq, 0);
      rdy_clr = 1'b1; edge1(); rdy_clr = 1'b0;
      chk("R9 clear idle", rdy_irq, 0);
    end

    @(posedge clk); #2 ext_rst_n = 1'b0; #1;
    chk("R1 async core", core_rst_n, 0);
    chk("R1 async oe", pad_oe, 0);
    edge1();

    @(posedge clk); #2 clk_en = 1'b0;
    #20 ext_rst_n = 1'b1;
    #200;
    chk("R3 no clock held", core_rst_n, 0);
    clk_en = 1'b1;
    repeat (RELEASE_EDGES + 2) edge1();
    chk("R3 release after clock", core_rst_n, 1);

    enter_reset(1'b1, 1'b0);
    repeat (8) edge1();
    #1 ext_rst_n = 1'b0; #1 ext_rst_n = 1'b1;
    chk("R4 mid count core", core_rst_n, 0);
    repeat (RELEASE_EDGES - 1) edge1();
    chk("R4 restarted held", core_rst_n, 0);
    edge1();
    chk("R4 restarted release", core_rst_n, 1);

    @(posedge clk); #2 ext_rst_n = 1'b0;
    rdy_clr = 1'b1;
    repeat (3) edge1();
    #1 ext_rst_n = 1'b1;
    repeat (4) edge1();
    rdy_clr = 1'b0;
    repeat (RELEASE_EDGES - 4) edge1();
    chk("R9 clear in reset ignored", rdy_irq, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule